// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block is a watchdog built around a free-running 32-bit up-counter and a programmable compare value. Software starts the counter and keeps rewinding it to zero before it climbs to the compare value. If it ever gets there, the block raises an interrupt flag. Depending on how it is configured, it can also stop and zero the counter, change the level on an external match pin, and emit a system reset pulse whose length is programmable. A sticky cause flag survives the watchdog's own reset, so that boot code can tell a watchdog restart from a power-on.

Software reaches the block through eight 32-bit word registers on a plain register port: a word index, a write strobe, write data and combinational read data. A write takes effect at the clock edge where the strobe is high. The port has no back-pressure, so every access completes in one cycle. There is no valid/ready handshake because no data stream crosses the block's edge. A debug-halt input can freeze the counter while a debugger holds the core.

The reset pulse comes in two kinds. The internal kind also returns the block's own configuration to its reset values. The external kind only drives the output.

Top module: `wdog_match_timer`

## Requirements
- R1: While `por_n` is low, every register reads 0 and `irq`, `match_pin` and `sys_rst_out` are low.
- R2: The counter (word 2, read-only) rises by one per clock while control bit 0 is set, unless control bit 2 and `dbg_halt` are both high. In every other case it holds.
- R3: A control write (word 1) with bit 1 set zeroes the counter at that edge. Bit 1 always reads 0, and bits 0 and 2 read back as written.
- R4: A match is the counter equalling the compare value (word 4) on a clock where the counter is running. A match sets status bit 0 (word 0) at the next edge. Writing 1 to that bit clears it, and a match on the same edge wins over the clear. `irq` is status bit 0 AND match-control bit 0.
- R5: With match-control bit 2 set (word 3), a match zeroes the counter and clears control bit 0 at the next edge, unless the control register is written in the same cycle.
- R6: External-match word 5: bits [5:4] give the action on match (0 none, 1 drive low, 2 drive high, 3 toggle). Bit 0 is the pin level, which `match_pin` follows, and a write loads bit 0 directly.
- R7: A match with match-control bit 3 (internal kind) or bit 4 (external kind) set raises `sys_rst_out` from the next edge for exactly L+6 cycles, where L is the 16-bit length in word 6.
- R8: Writing match-control bit 5 (internal) or bit 6 (external) starts the same pulse at once. These bits always read 0.
- R9: An internal-kind pulse clears words 0 to 6 at its first edge and keeps them at 0, ignoring writes, until it ends. An external-kind pulse leaves them alone.
- R10: Status word 7, bit 0, sets when any pulse starts. Writes and the pulse do not clear it; only `por_n` does.
- R11: A start request while a pulse is running is ignored, and neither the length nor the kind of the running pulse changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_widx | input | 3 | Word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word, combinational |
| dbg_halt | input | 1 | Debugger holds the core |
| irq | output | 1 | Match interrupt request |
| match_pin | output | 1 | External match pin level |
| sys_rst_out | output | 1 | Watchdog reset pulse, active high |

## Verification
Every register write, counter step, match consequence and pulse start appears one edge after the stimulus that causes it. Reads are combinational, so they show the updated value in that same following cycle. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. At the next falling edge it sweeps all eight words and the three outputs. Every comparison therefore falls exactly one edge after the cause. Pulse lengths are measured by counting the falling edges at which the reset output is high, and the count is compared against L+6.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [2:0] IDX_STAT  = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_COUNT = 3'd2;
  localparam logic [2:0] IDX_MCTL  = 3'd3;
  localparam logic [2:0] IDX_CMP   = 3'd4;
  localparam logic [2:0] IDX_PIN   = 3'd5;
  localparam logic [2:0] IDX_PLEN  = 3'd6;
  localparam logic [2:0] IDX_CAUSE = 3'd7;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  function automatic logic pin_after_match(input pin_act_e act, input logic cur);
    case (act)
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      PIN_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             zero_req,
  input  logic             stop_on_hit,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit   = run && (cnt_q == cmp_val);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr || zero_req)   cnt_q <= '0;
    else if (run) begin
      if (hit && stop_on_hit)   cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zero_req && !clr) |=> $stable(count)); // R2
  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (count == '0)); // R3
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PLEN_W = 16,
  parameter int OVH    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_int,
  input  logic              req_ext,
  input  logic [PLEN_W-1:0] len,
  output logic              active,
  output logic              start,
  output logic              self_clear
);
  localparam int RW = PLEN_W + $clog2(OVH + 1);

  logic          act_q, kind_int_q;
  logic [RW-1:0] rem_q;

  assign start      = (req_int || req_ext) && !act_q;
  assign self_clear = (start && req_int) || (act_q && kind_int_q);
  assign active     = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      kind_int_q <= 1'b0;
      rem_q      <= '0;
    end else if (start) begin
      act_q      <= 1'b1;
      kind_int_q <= req_int;
      rem_q      <= RW'(len) + RW'(OVH - 1);
    end else if (act_q) begin
      if (rem_q == '0) act_q <= 1'b0;
      else             rem_q <= rem_q - 1'b1;
    end
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(req_int || req_ext)); // R7
  AST_PULSE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> $stable(kind_int_q)); // R11
endmodule

// File: rtl/wdog_match_timer.sv
module wdog_match_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PLEN_W = 16,
  parameter int OVH    = 6
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic [2:0]  bus_widx,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_halt,
  output logic        irq,
  output logic        match_pin,
  output logic        sys_rst_out
);
  logic wr_stat, wr_ctrl, wr_mctl, wr_cmp, wr_pin, wr_plen;
  assign wr_stat = bus_we && (bus_widx == IDX_STAT);
  assign wr_ctrl = bus_we && (bus_widx == IDX_CTRL);
  assign wr_mctl = bus_we && (bus_widx == IDX_MCTL);
  assign wr_cmp  = bus_we && (bus_widx == IDX_CMP);
  assign wr_pin  = bus_we && (bus_widx == IDX_PIN);
  assign wr_plen = bus_we && (bus_widx == IDX_PLEN);

  logic              en_q, dbg_gate_q, flag_q;
  logic              ie_q, stop_q, rint_q, rext_q;
  logic [CNT_W-1:0]  cmp_q;
  pin_act_e          act_q;
  logic              pin_q;
  logic [PLEN_W-1:0] plen_q;
  logic              cause_q;

  logic              run, hit, req_int, req_ext;
  logic              p_active, p_start, self_clear;
  logic [CNT_W-1:0]  count;

  assign run     = en_q && !(dbg_gate_q && dbg_halt);
  assign req_int = (hit && rint_q) || (wr_mctl && bus_wdata[5]);
  assign req_ext = (hit && rext_q) || (wr_mctl && bus_wdata[6]);

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(por_n), .clr(self_clear), .run(run),
    .zero_req(wr_ctrl && bus_wdata[1]), .stop_on_hit(stop_q),
    .cmp_val(cmp_q), .count(count), .hit(hit)
  );

  wdt_pulse #(.PLEN_W(PLEN_W), .OVH(OVH)) u_pulse (
    .clk(clk), .rst_n(por_n), .req_int(req_int), .req_ext(req_ext),
    .len(plen_q), .active(p_active), .start(p_start), .self_clear(self_clear)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || self_clear) begin
      en_q <= 1'b0; dbg_gate_q <= 1'b0; flag_q <= 1'b0;
      ie_q <= 1'b0; stop_q <= 1'b0; rint_q <= 1'b0; rext_q <= 1'b0;
      cmp_q <= '0; act_q <= PIN_KEEP; pin_q <= 1'b0; plen_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q       <= bus_wdata[0];
        dbg_gate_q <= bus_wdata[2];
      end else if (hit && stop_q) begin
        en_q <= 1'b0;
      end
      if (hit)                          flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
      if (wr_mctl) begin
        ie_q   <= bus_wdata[0];
        stop_q <= bus_wdata[2];
        rint_q <= bus_wdata[3];
        rext_q <= bus_wdata[4];
      end
      if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
      if (wr_pin) begin
        act_q <= pin_act_e'(bus_wdata[5:4]);
        pin_q <= bus_wdata[0];
      end else if (hit) begin
        pin_q <= pin_after_match(act_q, pin_q);
      end
      if (wr_plen) plen_q <= bus_wdata[PLEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cause_q <= 1'b0;
    else if (p_start) cause_q <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_widx)
      IDX_STAT:  bus_rdata[0] = flag_q;
      IDX_CTRL:  begin bus_rdata[0] = en_q; bus_rdata[2] = dbg_gate_q; end
      IDX_COUNT: bus_rdata[CNT_W-1:0] = count;
      IDX_MCTL:  begin
        bus_rdata[0] = ie_q;   bus_rdata[2] = stop_q;
        bus_rdata[3] = rint_q; bus_rdata[4] = rext_q;
      end
      IDX_CMP:   bus_rdata[CNT_W-1:0] = cmp_q;
      IDX_PIN:   begin bus_rdata[5:4] = act_q; bus_rdata[0] = pin_q; end
      IDX_PLEN:  bus_rdata[PLEN_W-1:0] = plen_q;
      default:   bus_rdata[0] = cause_q;
    endcase
  end

  assign irq         = flag_q && ie_q;
  assign match_pin   = pin_q;
  assign sys_rst_out = p_active;

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!por_n)
    (hit && !self_clear) |=> flag_q); // R4
  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!por_n)
    (hit && stop_q && !self_clear && !wr_ctrl) |=> (!en_q && count == '0)); // R5
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    cause_q |=> cause_q); // R10
  AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    self_clear |=> (cmp_q == '0 && plen_q == '0 && !en_q)); // R9
endmodule

// File: tb/sim_wdog_match_timer.sv
module sim_wdog_match_timer;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [2:0]  bus_widx = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq, match_pin, sys_rst_out;

  always #10 clk = ~clk;

  wdog_match_timer u0 (
    .clk(clk), .por_n(por_n), .bus_widx(bus_widx), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .irq(irq), .match_pin(match_pin), .sys_rst_out(sys_rst_out)
  );

  int checks = 0, fails = 0, rst_hi = 0;
  bit done = 0;

  // behavioural reference state
  bit m_en, m_dbg, m_flag, m_ie, m_stop, m_ri, m_re, m_pin, m_act, m_kint, m_cause;
  bit [1:0] m_pact;
  bit [31:0] m_cnt, m_cmp;
  int m_plen, m_rem;

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_zero_cfg();
    m_en = 0; m_dbg = 0; m_flag = 0; m_ie = 0; m_stop = 0; m_ri = 0; m_re = 0;
    m_cmp = 0; m_pact = 0; m_pin = 0; m_plen = 0; m_cnt = 0;
  endtask

  task automatic model_edge(input bit [2:0] ix, input bit we_i, input bit [31:0] wd, input bit h);
    bit run, mev, ri, re, st, clr;
    if (!por_n) begin
      model_zero_cfg(); m_act = 0; m_kint = 0; m_rem = 0; m_cause = 0;
      return;
    end
    run = m_en && !(m_dbg && h);
    mev = run && (m_cnt == m_cmp);
    ri = (mev && m_ri) || (we_i && ix == 3 && wd[5]);
    re = (mev && m_re) || (we_i && ix == 3 && wd[6]);
    st = (ri || re) && !m_act;
    clr = (st && ri) || (m_act && m_kint);
    if (st) begin m_act = 1; m_rem = m_plen + 5; m_kint = ri; m_cause = 1; end
    else if (m_act) begin if (m_rem == 0) m_act = 0; else m_rem--; end
    if (clr) begin model_zero_cfg(); return; end
    if (we_i && ix == 1 && wd[1]) m_cnt = 0;
    else if (run) m_cnt = (mev && m_stop) ? 0 : m_cnt + 1;
    if (we_i && ix == 1) begin m_en = wd[0]; m_dbg = wd[2]; end
    else if (mev && m_stop) m_en = 0;
    if (mev) m_flag = 1;
    else if (we_i && ix == 0 && wd[0]) m_flag = 0;
    if (we_i && ix == 5) begin m_pact = wd[5:4]; m_pin = wd[0]; end
    else if (mev) begin
      if (m_pact == 1) m_pin = 0;
      else if (m_pact == 2) m_pin = 1;
      else if (m_pact == 3) m_pin = !m_pin;
    end
    if (we_i && ix == 3) begin m_ie = wd[0]; m_stop = wd[2]; m_ri = wd[3]; m_re = wd[4]; end
    if (we_i && ix == 4) m_cmp = wd;
    if (we_i && ix == 6) m_plen = int'(wd[15:0]);
  endtask

  function automatic logic [31:0] exp_word(input int i);
    case (i)
      0: return {31'd0, m_flag};
      1: return {29'd0, m_dbg, 1'b0, m_en};
      2: return m_cnt;
      3: return {27'd0, m_re, m_ri, m_stop, 1'b0, m_ie};
      4: return m_cmp;
      5: return {26'd0, m_pact, 3'd0, m_pin};
      6: return m_plen[31:0];
      default: return {31'd0, m_cause};
    endcase
  endfunction

  // compare every word and every output against the model (called at negedge)
  task automatic check_all();
    string tags[8] = '{"R4", "R3", "R2", "R8", "R9", "R6", "R9", "R10"};
    bus_we = 0;
    for (int i = 0; i < 8; i++) begin
      bus_widx = 3'(i);
      #1;
      cmp(tags[i], $sformatf("word%0d", i), bus_rdata, exp_word(i));
    end
    cmp("R4", "irq", {31'd0, irq}, {31'd0, m_flag && m_ie});
    cmp("R6", "match_pin", {31'd0, match_pin}, {31'd0, m_pin});
    cmp("R7", "sys_rst_out", {31'd0, sys_rst_out}, {31'd0, m_act});
    if (sys_rst_out) rst_hi++;
  endtask

  task automatic step(input bit [2:0] ix, input bit we_i, input bit [31:0] wd);
    bus_widx = ix; bus_we = we_i; bus_wdata = wd;
    @(posedge clk);
    model_edge(ix, we_i, wd, dbg_halt);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(3'd0, 1'b0, 32'd0);
  endtask

  function automatic logic [31:0] rd(input bit [2:0] ix);
    return exp_word(ix);
  endfunction

  task automatic read_port(input bit [2:0] ix, output logic [31:0] v);
    bus_we = 0; bus_widx = ix; #1; v = bus_rdata;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    @(negedge clk);
    model_edge(0, 0, 0, 0);
    step(0, 0, 0); step(0, 0, 0);
    // R1: reset state
    read_port(3'd7, v); cmp("R1", "cause in reset", v, 32'd0);
    cmp("R1", "outputs in reset", {29'd0, irq, match_pin, sys_rst_out}, 32'd0);
    por_n = 1;
    idle(2);

    // R2/R4: free run to compare value with interrupt enabled
    step(4, 1, 32'd20);
    step(3, 1, 32'h1);
    step(1, 1, 32'h1);
    idle(30);
    cmp("R4", "irq after match", {31'd0, irq}, 32'd1);
    step(0, 1, 32'h1);
    cmp("R4", "irq after clear", {31'd0, irq}, 32'd0);

    // R2: debug freeze gate
    step(1, 1, 32'h5);
    dbg_halt = 1;
    idle(5);
    read_port(3'd2, v); cmp("R2", "frozen counter", v, m_cnt);
    step(1, 1, 32'h1);
    idle(4);
    dbg_halt = 0;

    // R3: zero request
    step(1, 1, 32'h2);
    read_port(3'd2, v); cmp("R3", "counter zeroed", v, 32'd0);
    read_port(3'd1, v); cmp("R3", "ctrl readback", v, 32'd0);

    // R5/R6: stop on match with pin actions
    step(5, 1, 32'h20);
    step(4, 1, 32'd10);
    step(3, 1, 32'h5);
    step(1, 1, 32'h1);
    idle(15);
    cmp("R6", "pin driven high", {31'd0, match_pin}, 32'd1);
    read_port(3'd2, v); cmp("R5", "counter after stop", v, 32'd0);
    read_port(3'd1, v); cmp("R5", "enable after stop", v, 32'd0);
    step(5, 1, 32'h30);
    step(1, 1, 32'h1); idle(15);
    cmp("R6", "toggle once", {31'd0, match_pin}, 32'd1);
    step(1, 1, 32'h1); idle(15);
    cmp("R6", "toggle twice", {31'd0, match_pin}, 32'd0);
    step(5, 1, 32'h11);
    step(1, 1, 32'h1); idle(15);
    cmp("R6", "drive low", {31'd0, match_pin}, 32'd0);

    // R7/R9/R11: external pulse on match, restart attempt ignored
    step(6, 1, 32'd3);
    step(4, 1, 32'd5);
    step(3, 1, 32'h14);
    rst_hi = 0;
    step(1, 1, 32'h1);
    idle(8);
    step(3, 1, 32'h50);
    idle(20);
    cmp("R7", "external pulse length", rst_hi, 32'd9);
    cmp("R11", "no restart", rst_hi, 32'd9);
    read_port(3'd4, v); cmp("R9", "compare kept by external pulse", v, 32'd5);
    read_port(3'd7, v); cmp("R10", "cause set", v, 32'd1);

    // R8/R9: forced internal pulse clears and locks configuration
    step(6, 1, 32'd2);
    rst_hi = 0;
    step(3, 1, 32'h20);
    step(4, 1, 32'h77);
    idle(15);
    cmp("R8", "forced pulse length", rst_hi, 32'd8);
    read_port(3'd4, v); cmp("R9", "compare cleared", v, 32'd0);
    read_port(3'd6, v); cmp("R9", "length cleared", v, 32'd0);

    // R10: cause sticky against writes, cleared by power-on only
    step(7, 1, 32'h0);
    read_port(3'd7, v); cmp("R10", "cause after write", v, 32'd1);
    por_n = 0;
    step(0, 0, 0);
    read_port(3'd7, v); cmp("R10", "cause after por", v, 32'd0);
    v = rd(3'd7);
    por_n = 1;
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule